// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Controller

This block is a synthesizable behavioural model of the control side of a byte-wide one-time-programmable memory. It looks at five control inputs: an active-low chip select, an active-low output gate, an active-low program strobe, a flag that says the programming supply is present, and a flag that says the high identification voltage is present on an address line. From these it decides what the part is doing: standby, output disabled, read, identification, program, program verify, program inhibit, or a refused programming combination. The decision is reported on a 3-bit mode output.

Storage is a small register file that holds all ones after reset. Programming can only clear bits. Each falling edge of the program strobe is sampled on the system clock and causes at most one write. The byte-wide data port is modelled as a data bus plus a separate drive-enable. When the drive-enable is low the bus carries zero, which stands for high impedance. In identification mode the port returns fixed odd-parity identifier bytes instead of array contents. The two address bits below the identification line select which byte.

Top module: `otp_mode_ctrl`

## Requirements
- R1: `dout_oe` is high only when `ce_n` and `oe_n` are both low and the mode is read (2), identification (3) or verify (5). Whenever `dout_oe` is low, `dout` is 8'h00.
- R2: With `ce_n` high, the mode is standby (0) if `vpp_on` is low and inhibit (6) if `vpp_on` is high. The port is not driven in either case, whatever the level of `oe_n`. This is also the state out of reset.
- R3: Read mode (2) is entered when `ce_n`, `oe_n`, `vpp_on` and `id_hv` are all low. It drives the stored byte at `addr`. After reset every word reads 8'hFF.
- R4: Program mode (4) is entered when `vpp_on` is high, `ce_n` is low, `oe_n` is high and `prog_n` is low. At the first clock edge where `prog_n` is sampled low after being sampled high, the word at `addr` becomes its old value AND `din`. A bit is never set.
- R5: A strobe that stays low performs no further write, even if `din` changes. If program mode is entered while `prog_n` is already low, nothing is written.
- R6: A strobe pulse in inhibit mode (6) leaves the array unchanged.
- R7: Verify mode (5) is entered when `vpp_on` is high, `ce_n` and `oe_n` are low and `prog_n` is high. It drives the stored byte at `addr`.
- R8: Identification mode (3) is entered when `id_hv` is high under read conditions. With addr[1]=1, addr[0]=0 returns 8'h1C and addr[0]=1 returns 8'h01. With addr[1]=0 the result is 8'h7F. Higher address bits have no effect.
- R9: Every identification byte has odd parity over its 8 bits, and bit 7 is the parity bit.
- R10: Mode 7 (refused) is reported when `vpp_on` is high and `ce_n`, `oe_n` and `prog_n` are all low. A strobe falling edge in this mode writes nothing. `prog_err` is raised from the next cycle and stays high until `prog_n` is sampled high.
- R11: Output-disabled mode (1) is reported when `ce_n` is low and `oe_n` is high, with either `vpp_on` low or with `vpp_on` high and `prog_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the program strobe |
| rst_n | input | 1 | Active-low asynchronous reset; fills the array with ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| prog_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | Programming supply present |
| id_hv | input | 1 | High identification voltage present |
| addr | input | AW | Word address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Data out (zero when not driven) |
| dout_oe | output | 1 | Data port drive enable |
| mode | output | 3 | Decoded operating mode code |
| prog_err | output | 1 | Refused-programming flag |

## Verification
The bench holds a strobe low across several cycles while changing `din`. A design that writes on level instead of on edge would clear extra bits. It also raises the supply with the strobe already low, where an edge detector primed by the mode change would write spuriously. Strobe pulses are sent with chip select high and with the output gate low. A decoder that lets either through would corrupt words that later reads expose. The identification bytes are read with upper address bits set and with addr[1] low, which catches a decoder that uses the wrong bits or forgets the continuation code. Long random sequences then compare every mode, drive enable, byte and error flag against a bench model.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int OTP_DW = 8;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_OUTOFF  = 3'd1,
        MODE_READ    = 3'd2,
        MODE_IDENT   = 3'd3,
        MODE_PROG    = 3'd4,
        MODE_VERIFY  = 3'd5,
        MODE_INHIBIT = 3'd6,
        MODE_REFUSE  = 3'd7
    } otp_mode_e;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_BURN    = 2'd1,
        PS_REFUSED = 2'd2
    } burn_state_e;

    localparam logic [6:0] ID_MAKER_LO = 7'h1C;
    localparam logic [6:0] ID_PART_LO  = 7'h01;
    localparam logic [6:0] ID_CONT_LO  = 7'h7F;

    // Bit 7 is chosen so that the whole byte carries an odd number of ones.
    function automatic logic [OTP_DW-1:0] odd_par_byte(input logic [6:0] low7);
        return {~^low7, low7};
    endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      prog_n,
    input  logic      vpp_on,
    input  logic      id_hv,
    output otp_mode_e mode
);

    logic [3:0] ctl;
    assign ctl = {ce_n, vpp_on, oe_n, prog_n};

    always_comb begin
        unique casez (ctl)
            4'b10??: mode = MODE_STANDBY;
            4'b11??: mode = MODE_INHIBIT;
            4'b001?: mode = MODE_OUTOFF;
            4'b000?: mode = id_hv ? MODE_IDENT : MODE_READ;
            4'b0110: mode = MODE_PROG;
            4'b0111: mode = MODE_OUTOFF;
            4'b0101: mode = MODE_VERIFY;
            4'b0100: mode = MODE_REFUSE;
            default: mode = MODE_STANDBY;
        endcase
    end

endmodule

// File: rtl/otp_id_sel.sv
module otp_id_sel
    import otp_pkg::*;
(
    input  logic [1:0]        sel,
    output logic [OTP_DW-1:0] id_byte
);

    always_comb begin
        unique case (sel)
            2'b10:   id_byte = odd_par_byte(ID_MAKER_LO);
            2'b11:   id_byte = odd_par_byte(ID_PART_LO);
            default: id_byte = odd_par_byte(ID_CONT_LO);
        endcase
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [OTP_DW-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [OTP_DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [OTP_DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [OTP_DW-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (we && (waddr == AW'(i))) begin
                cell_q <= cell_q & wdata;
            end
        end
        assign words[i] = cell_q;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/otp_burn_fsm.sv
module otp_burn_fsm
    import otp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      prog_n,
    input  otp_mode_e mode,
    output logic      wr_en,
    output logic      refused
);

    burn_state_e state_q, state_d;
    logic        strobe_q;
    logic        strobe_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            strobe_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            strobe_q <= prog_n;
        end
    end

    assign strobe_fall = strobe_q && !prog_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (strobe_fall && (mode == MODE_PROG)) begin
                    state_d = PS_BURN;
                end else if (strobe_fall && (mode == MODE_REFUSE)) begin
                    state_d = PS_REFUSED;
                end
            end
            PS_BURN: begin
                if (prog_n) state_d = PS_IDLE;
            end
            PS_REFUSED: begin
                if (prog_n) state_d = PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        wr_en   = (state_q == PS_IDLE) && strobe_fall && (mode == MODE_PROG);
        refused = (state_q == PS_REFUSED);
    end

endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic [AW-1:0]     addr,
    input  logic [OTP_DW-1:0] din,
    output logic [OTP_DW-1:0] dout,
    output logic              dout_oe,
    output logic [2:0]        mode,
    output logic              prog_err
);

    otp_mode_e         cur_mode;
    logic              wr_en;
    logic [OTP_DW-1:0] cell_byte;
    logic [OTP_DW-1:0] id_byte;

    otp_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .prog_n (prog_n),
        .vpp_on (vpp_on),
        .id_hv  (id_hv),
        .mode   (cur_mode)
    );

    otp_burn_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_n  (prog_n),
        .mode    (cur_mode),
        .wr_en   (wr_en),
        .refused (prog_err)
    );

    otp_cell_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (addr),
        .wdata (din),
        .raddr (addr),
        .rdata (cell_byte)
    );

    otp_id_sel u_id (
        .sel     (addr[1:0]),
        .id_byte (id_byte)
    );

    always_comb begin
        unique case (cur_mode)
            MODE_READ, MODE_VERIFY: begin
                dout_oe = 1'b1;
                dout    = cell_byte;
            end
            MODE_IDENT: begin
                dout_oe = 1'b1;
                dout    = id_byte;
            end
            default: begin
                dout_oe = 1'b0;
                dout    = '0;
            end
        endcase
    end

    assign mode = cur_mode;

endmodule

// File: rtl/otp_mode_ctrl_chk.sv
module otp_mode_ctrl_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          prog_n,
    input logic [AW-1:0] addr,
    input logic [7:0]    dout,
    input logic          dout_oe,
    input logic [2:0]    mode,
    input logic          prog_err
);

    // R1
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!ce_n && !oe_n));

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dout_oe && ((mode == 3'd0) || (mode == 3'd6))));

    // R8
    id_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd3) && !addr[1]) |-> (dout == 8'h7F));

    // R9
    id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (^dout));

    // R10
    refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prog_n) && (mode == 3'd7)) |=> prog_err);

    // R10
    refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !prog_n) |=> prog_err);

endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .prog_n   (prog_n),
    .addr     (addr),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .mode     (mode),
    .prog_err (prog_err)
);

// File: tb/sim_otp_mode_ctrl.sv
`timescale 1ns/1ps
module sim_otp_mode_ctrl;

    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1, vpp_on = 1'b0, id_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_oe;
    logic [2:0]    mode;
    logic          prog_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mdl [DEPTH];
    bit prev_pg = 1'b1;
    bit rej = 1'b0;

    always #2.5 clk = ~clk;

    otp_mode_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_n(prog_n),
        .vpp_on(vpp_on), .id_hv(id_hv), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .mode(mode), .prog_err(prog_err)
    );

    function automatic logic [2:0] f_mode(input logic ce, oe, pg, vpp, hv);
        if (ce) return vpp ? 3'd6 : 3'd0;
        if (!vpp) return oe ? 3'd1 : (hv ? 3'd3 : 3'd2);
        if (oe) return pg ? 3'd1 : 3'd4;
        return pg ? 3'd5 : 3'd7;
    endfunction

    function automatic logic [7:0] f_id(input logic [AW-1:0] a);
        if (!a[1]) return 8'h7F;
        return a[0] ? 8'h01 : 8'h1C;
    endfunction

    task automatic step(input logic ce, oe, pg, vpp, hv,
                        input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        logic [2:0] em;
        logic       eoe;
        logic [7:0] ed;
        bit         fall;
        @(negedge clk);
        ce_n = ce; oe_n = oe; prog_n = pg; vpp_on = vpp; id_hv = hv; addr = a; din = d;
        #1;
        em  = f_mode(ce, oe, pg, vpp, hv);
        eoe = (em == 3'd2) || (em == 3'd3) || (em == 3'd5);
        ed  = !eoe ? 8'h00 : ((em == 3'd3) ? f_id(a) : mdl[a]);
        checks++;
        if ({mode, dout_oe, dout, prog_err} !== {em, eoe, ed, rej}) begin
            errors++;
            $display("FAIL %s: mode/oe/dout/err = %0d/%0b/%02h/%0b expected %0d/%0b/%02h/%0b",
                     tag, mode, dout_oe, dout, prog_err, em, eoe, ed, rej);
        end
        if (em == 3'd3) begin
            checks++;
            if (^dout !== 1'b1) begin
                errors++;
                $display("FAIL R9: id byte %02h parity %0b expected 1", dout, ^dout);
            end
        end
        fall = prev_pg && !pg;
        if (fall && em == 3'd4) mdl[a] = mdl[a] & d;
        rej = fall ? (em == 3'd7) : (rej && !pg);
        prev_pg = pg;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        checks++;  // R2 reset state
        if ({mode, dout_oe, dout, prog_err} !== {3'd0, 1'b0, 8'h00, 1'b0}) begin
            errors++;
            $display("FAIL R2: reset outputs %0d/%0b/%02h/%0b expected 0/0/00/0",
                     mode, dout_oe, dout, prog_err);
        end
        rst_n = 1'b1;

        // R3 fresh array reads all ones
        step(0, 0, 1, 0, 0, 5'd0, 8'h00, "R3");
        step(0, 0, 1, 0, 0, 5'd31, 8'h00, "R3");
        // R2 deselected with output gate low
        step(1, 0, 1, 0, 0, 5'd4, 8'h00, "R2");
        // R4 single write then verify (R7) and read (R3)
        step(0, 1, 1, 1, 0, 5'd3, 8'hA5, "R11");
        step(0, 1, 0, 1, 0, 5'd3, 8'hA5, "R4");
        step(0, 1, 1, 1, 0, 5'd3, 8'hA5, "R4");
        step(0, 0, 1, 1, 0, 5'd3, 8'h00, "R7");
        // R4 second write only clears
        step(0, 1, 0, 1, 0, 5'd3, 8'h3C, "R4");
        step(0, 1, 1, 1, 0, 5'd3, 8'hFF, "R4");
        step(0, 0, 1, 0, 0, 5'd3, 8'h00, "R4");
        // R5 strobe held low, data changes
        step(0, 1, 0, 1, 0, 5'd7, 8'hF0, "R5");
        step(0, 1, 0, 1, 0, 5'd7, 8'h0F, "R5");
        step(0, 1, 0, 1, 0, 5'd7, 8'h00, "R5");
        step(0, 1, 1, 1, 0, 5'd7, 8'h00, "R5");
        step(0, 0, 1, 1, 0, 5'd7, 8'h00, "R5");
        // R5 supply raised with strobe already low
        step(0, 1, 0, 0, 0, 5'd9, 8'h00, "R11");
        step(0, 1, 0, 1, 0, 5'd9, 8'h00, "R5");
        step(0, 1, 0, 1, 0, 5'd9, 8'h00, "R5");
        step(0, 1, 1, 1, 0, 5'd9, 8'h00, "R5");
        step(0, 0, 1, 0, 0, 5'd9, 8'h00, "R5");
        // R6 inhibit pulse
        step(1, 1, 1, 1, 0, 5'd10, 8'h00, "R6");
        step(1, 1, 0, 1, 0, 5'd10, 8'h00, "R6");
        step(1, 1, 1, 1, 0, 5'd10, 8'h00, "R6");
        step(0, 0, 1, 1, 0, 5'd10, 8'h00, "R6");
        // R10 refused combination
        step(0, 0, 1, 1, 0, 5'd11, 8'h00, "R10");
        step(0, 0, 0, 1, 0, 5'd11, 8'h00, "R10");
        step(0, 0, 0, 1, 0, 5'd11, 8'h00, "R10");
        step(0, 0, 1, 1, 0, 5'd11, 8'h00, "R10");
        step(0, 0, 1, 1, 0, 5'd11, 8'h00, "R10");
        // R8 identification, with upper bits set
        step(0, 0, 1, 0, 1, 5'b00010, 8'h00, "R8");
        step(0, 0, 1, 0, 1, 5'b00011, 8'h00, "R8");
        step(0, 0, 1, 0, 1, 5'b11110, 8'h00, "R8");
        step(0, 0, 1, 0, 1, 5'b10000, 8'h00, "R8");
        step(0, 0, 1, 0, 1, 5'b10101, 8'h00, "R8");
        // R11 output disabled, strobe low with no supply
        step(0, 1, 0, 0, 0, 5'd12, 8'h00, "R11");
        step(0, 1, 1, 0, 0, 5'd12, 8'h00, "R11");
        step(0, 0, 1, 0, 0, 5'd12, 8'h00, "R3");

        // Random mix, R1 over every mode
        for (int n = 0; n < 1500; n++) begin
            logic ce, oe, pg, vpp, hv;
            ce  = ($urandom_range(0, 3) == 0);
            oe  = $urandom_range(0, 1);
            pg  = $urandom_range(0, 1);
            vpp = ($urandom_range(0, 2) != 0);
            hv  = ($urandom_range(0, 6) == 0);
            step(ce, oe, pg, vpp, hv, AW'($urandom_range(0, DEPTH - 1)),
                 8'($urandom), "R1");
        end
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, AW'(i), 8'h00, "R3");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule